// File: doc/BRIEF.md
# Prescaled I2C Master Line Sequencer

This block generates the open-drain line activity of an I2C bus master from a single functional clock. A command port asks for a START (or a repeated START while the bus is held), a byte write, a byte read or a STOP. The block then steps through fixed timing phases and asserts only pull-low enables for SCL and SDA. It never drives either line high, so the pads outside stay open-drain.

Every phase length is a programmable count times a power-of-two prescale factor. One prescale value is loaded for each bus speed class, and the mode select picks which one applies. A single setup/hold count times the edges of the START, repeated START and STOP conditions. Separate counts set the SCL low period, the SCL high period, the data hold delay after SCL falls and the bus release time after a STOP.

A bus watcher marks the bus as free when it sees a STOP. It also marks the bus free when both lines have stayed high for a programmed idle interval, which lets the master recover when another device abandons a transfer. A START from idle is accepted only while the bus is free.

Top module: `i2cm_timing_master`

## Requirements
- R1: While reset is asserted and right after it, both pull enables are low, busy, bus_free, nack and rx_data are all zero.
- R2: Each timed phase lasts max(count,1)·2^P clock cycles. P is presc_std when mode=0, presc_fast when mode=1 and presc_fplus when mode is 2 or 3.
- R3: bus_free clears in the cycle after either line is seen low. It sets after both lines have been high for max(t_idle,1)·2^P consecutive cycles, even when no STOP was seen. A START (cmd_op=0) issued in idle while bus_free is low is ignored.
- R4: A START from idle pulls SDA while SCL is released for the t_sethold interval. It then pulls SCL and holds the bus with both lines low.
- R5: A START while the bus is held is a repeated START. SDA is released during one t_low interval with SCL low. SCL is then released for t_sethold, SDA is pulled for t_sethold, and finally SCL is pulled.
- R6: A byte (cmd_op=1 write, cmd_op=2 read) makes nine SCL pulses, each held high for t_high. From bit 1 onward each SCL low period lasts t_low, and SDA may change only t_dhold after SCL falls. A write sends cmd_wdata MSB first and releases SDA on the ninth bit.
- R7: During data bits the SDA pull enable never changes while SCL is released.
- R8: SDA is sampled at the end of each SCL high phase. rx_data collects the eight read bits MSB first. nack takes the line level of the ninth bit. On a read, the ninth bit is pulled low by the master exactly when cmd_mack=1.
- R9: A STOP (cmd_op=3) pulls SDA and keeps SCL low for t_low. It then releases SCL for t_sethold and releases SDA. The bus stays idle for t_buf before busy drops, and bus_free is set by the STOP it produced.
- R10: A command arriving while a phase runs is ignored, and so are WRITE, READ and STOP in idle.
- R11: busy is high from an accepted START until the end of the t_buf phase. While busy is low, both pull enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Speed class: 0 standard, 1 fast, 2/3 fast-plus |
| presc_std | input | PW | Prescale exponent for mode 0 |
| presc_fast | input | PW | Prescale exponent for mode 1 |
| presc_fplus | input | PW | Prescale exponent for modes 2 and 3 |
| t_low | input | CW | SCL low count |
| t_high | input | CW | SCL high count |
| t_dhold | input | CW | Data hold count after SCL falls |
| t_sethold | input | CW | Shared START/STOP setup and hold count |
| t_buf | input | CW | Bus release count after STOP |
| t_idle | input | CW | Bus idle timeout count |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | input | 8 | Byte to write |
| cmd_mack | input | 1 | On a read, pull the ninth bit low |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| rx_data | output | 8 | Last byte read |
| nack | output | 1 | Ninth-bit line level of the last byte |
| busy | output | 1 | Transaction in progress |
| bus_free | output | 1 | Bus judged free |

## Verification
The assertions take for granted that the sensed line levels are the wired-AND of this master's pull enables and any other device's. They also assume a command is a one-cycle strobe and that t_low is larger than t_dhold. Configuration and mode are assumed to change only while no phase is running. The stimulus models the lines as continuous wired-AND nets and drives the slave's SDA only at SCL falling edges. It issues every command for exactly one cycle and changes mode only between transactions with the bus held or idle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_STA_HOLD, S_HOLD, S_RS_LOW, S_RS_SETUP,
    S_BIT_DH, S_BIT_LOW, S_BIT_HIGH, S_SP_LOW, S_SP_SETUP, S_SP_BUF
  } phase_e;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  // Cycles spent in a phase: a zero count behaves as one unit.
  function automatic logic [31:0] scaled_len(input logic [31:0] count,
                                             input logic [31:0] presc);
    logic [31:0] unit_cnt;
    unit_cnt = (count == 32'd0) ? 32'd1 : count;
    return unit_cnt << presc;
  endfunction

endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int CW = 12,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [PW-1:0] presc,
  output logic          expire
);
  localparam int SW = (1 << PW) - 1;

  logic [CW-1:0] units;
  logic [SW-1:0] sub;
  logic [SW-1:0] mask;

  assign mask   = ~({SW{1'b1}} << presc);
  assign expire = (units == CW'(1)) && (sub == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      units <= '0;
      sub   <= '0;
    end else if (load) begin
      units <= (load_val == '0) ? CW'(1) : load_val;
      sub   <= '0;
    end else if (units != '0) begin
      if (sub == mask) begin
        sub   <= '0;
        units <= units - CW'(1);
      end else begin
        sub <= sub + SW'(1);
      end
    end
  end

  // R2
  count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (units <= $past(units)));

endmodule

// File: rtl/i2cm_bus_watch.sv
module i2cm_bus_watch #(
  parameter int CW = 12,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [CW-1:0] t_idle,
  input  logic [PW-1:0] presc,
  output logic          bus_free
);
  import i2cm_pkg::*;
  localparam int RW = CW + (1 << PW) - 1;

  logic [RW-1:0] run;
  logic [RW-1:0] limit;
  logic          prev_scl, prev_sda;
  logic          stop_seen;
  logic          lines_high;

  assign limit      = RW'(scaled_len(32'(t_idle), 32'(presc)));
  assign lines_high = scl_in && sda_in;
  assign stop_seen  = prev_scl && scl_in && !prev_sda && sda_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= '0;
      bus_free <= 1'b0;
      prev_scl <= 1'b0;
      prev_sda <= 1'b0;
    end else begin
      prev_scl <= scl_in;
      prev_sda <= sda_in;
      if (!lines_high) begin
        run      <= '0;
        bus_free <= 1'b0;
      end else begin
        if (run != limit) run <= run + RW'(1);
        if (stop_seen || (run >= limit - RW'(1))) bus_free <= 1'b1;
      end
    end
  end

  // R3
  free_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lines_high |=> !bus_free);
  // R3
  free_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(lines_high));

endmodule

// File: rtl/i2cm_timing_master.sv
module i2cm_timing_master #(
  parameter int CW = 12,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] presc_std,
  input  logic [PW-1:0] presc_fast,
  input  logic [PW-1:0] presc_fplus,
  input  logic [CW-1:0] t_low,
  input  logic [CW-1:0] t_high,
  input  logic [CW-1:0] t_dhold,
  input  logic [CW-1:0] t_sethold,
  input  logic [CW-1:0] t_buf,
  input  logic [CW-1:0] t_idle,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_wdata,
  input  logic          cmd_mack,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic [7:0]    rx_data,
  output logic          nack,
  output logic          busy,
  output logic          bus_free
);
  import i2cm_pkg::*;
  localparam logic [3:0] LAST_BIT = 4'd8;

  phase_e        st, st_nx;
  logic          sda_reg, sda_nx;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          expire;
  logic [PW-1:0] presc;
  logic [3:0]    bit_idx;
  logic [7:0]    shreg, rx;
  logic          is_read, mack_r, nack_r;
  logic          bit_pull;
  logic          byte_go, bit_done, ack_take;

  // Prescale exponent for the selected speed class
  always_comb begin
    case (mode)
      2'd0:    presc = presc_std;
      2'd1:    presc = presc_fast;
      default: presc = presc_fplus;
    endcase
  end

  i2cm_phase_timer #(.CW(CW), .PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .presc(presc), .expire(expire));

  i2cm_bus_watch #(.CW(CW), .PW(PW)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .t_idle(t_idle), .presc(presc), .bus_free(bus_free));

  always_comb begin
    if (is_read) bit_pull = (bit_idx == LAST_BIT) ? mack_r : 1'b0;
    else         bit_pull = (bit_idx == LAST_BIT) ? 1'b0 : ~shreg[7];
  end

  assign byte_go  = (st == S_HOLD) && cmd_valid &&
                    ((cmd_op == OP_WRITE) || (cmd_op == OP_READ));
  assign bit_done = (st == S_BIT_HIGH) && expire;
  assign ack_take = bit_done && (bit_idx == LAST_BIT);

  always_comb begin
    st_nx  = st;
    sda_nx = sda_reg;
    ld     = 1'b0;
    ld_val = '0;
    case (st)
      S_IDLE:
        if (cmd_valid && cmd_op == OP_START && bus_free) begin
          st_nx = S_STA_HOLD; ld = 1'b1; ld_val = t_sethold; sda_nx = 1'b1;
        end
      S_STA_HOLD:
        if (expire) st_nx = S_HOLD;
      S_HOLD:
        if (cmd_valid) begin
          ld = 1'b1;
          case (cmd_op)
            OP_START: begin st_nx = S_RS_LOW; ld_val = t_low; sda_nx = 1'b0; end
            OP_STOP:  begin st_nx = S_SP_LOW; ld_val = t_low; sda_nx = 1'b1; end
            default:  begin st_nx = S_BIT_DH; ld_val = t_dhold; end
          endcase
        end
      S_RS_LOW:
        if (expire) begin st_nx = S_RS_SETUP; ld = 1'b1; ld_val = t_sethold; end
      S_RS_SETUP:
        if (expire) begin
          st_nx = S_STA_HOLD; ld = 1'b1; ld_val = t_sethold; sda_nx = 1'b1;
        end
      S_BIT_DH:
        if (expire) begin
          st_nx = S_BIT_LOW; ld = 1'b1; ld_val = t_low - t_dhold; sda_nx = bit_pull;
        end
      S_BIT_LOW:
        if (expire) begin st_nx = S_BIT_HIGH; ld = 1'b1; ld_val = t_high; end
      S_BIT_HIGH:
        if (expire) begin
          if (bit_idx == LAST_BIT) st_nx = S_HOLD;
          else begin st_nx = S_BIT_DH; ld = 1'b1; ld_val = t_dhold; end
        end
      S_SP_LOW:
        if (expire) begin st_nx = S_SP_SETUP; ld = 1'b1; ld_val = t_sethold; end
      S_SP_SETUP:
        if (expire) begin
          st_nx = S_SP_BUF; ld = 1'b1; ld_val = t_buf; sda_nx = 1'b0;
        end
      S_SP_BUF:
        if (expire) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sda_reg <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      rx      <= '0;
      is_read <= 1'b0;
      mack_r  <= 1'b0;
      nack_r  <= 1'b0;
    end else begin
      st      <= st_nx;
      sda_reg <= sda_nx;
      if (byte_go) begin
        bit_idx <= '0;
        shreg   <= cmd_wdata;
        is_read <= (cmd_op == OP_READ);
        mack_r  <= cmd_mack;
      end else if (bit_done) begin
        bit_idx <= bit_idx + 4'd1;
        shreg   <= {shreg[6:0], 1'b0};
        if (ack_take) nack_r <= sda_in;
        else          rx     <= {rx[6:0], sda_in};
      end
    end
  end

  assign scl_pull = (st == S_HOLD) || (st == S_RS_LOW) || (st == S_BIT_DH) ||
                    (st == S_BIT_LOW) || (st == S_SP_LOW);
  assign sda_pull = sda_reg;
  assign busy     = (st != S_IDLE);
  assign rx_data  = rx;
  assign nack     = nack_r;

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));
  // R3
  start_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_free));
  // R7
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT_HIGH) |-> $stable(sda_pull));
  // R8
  nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_take |=> $stable(nack));

endmodule

// File: tb/i2cm_timing_master_bench.sv
module i2cm_timing_master_bench;
  localparam int CW = 12, PW = 3;
  localparam int LOWC = 10, HIGHC = 8, DHC = 3, SHC = 5, BUFC = 12, IDLEC = 20;
  localparam int PS_STD = 1, PS_FAST = 0, PS_FP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic cmd_valid = 1'b0, cmd_mack = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic ext_scl = 1'b0, ext_sda = 1'b0;
  logic scl_ln, sda_ln, scl_pull, sda_pull, nack, busy, bus_free;
  logic [7:0] rx_data;

  assign scl_ln = ~(scl_pull | ext_scl);
  assign sda_ln = ~(sda_pull | ext_sda);

  always #2 clk = ~clk;

  i2cm_timing_master #(.CW(CW), .PW(PW)) u_i2cm_timing_master (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .presc_std(PW'(PS_STD)), .presc_fast(PW'(PS_FAST)), .presc_fplus(PW'(PS_FP)),
    .t_low(CW'(LOWC)), .t_high(CW'(HIGHC)), .t_dhold(CW'(DHC)),
    .t_sethold(CW'(SHC)), .t_buf(CW'(BUFC)), .t_idle(CW'(IDLEC)),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_mack(cmd_mack),
    .scl_in(scl_ln), .sda_in(sda_ln), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .rx_data(rx_data), .nack(nack), .busy(busy), .bus_free(bus_free));

  int checks = 0, fails = 0, ticks = 0;
  int exp_q[$];
  logic slave_bits [9];
  logic in_byte = 1'b0, prev_in = 1'b0, prev_scl = 1'b0, prev_sdp = 1'b0;
  logic last_sda = 1'b1, hi_changed = 1'b0, seen_fall = 1'b0;
  int hi = 0, lo = 0, bidx = 0;

  function automatic int cyc(input int n, input int p);
    return ((n == 0) ? 1 : n) << p;
  endfunction

  function automatic int cur_p();
    return (mode == 2'd0) ? PS_STD : (mode == 2'd1) ? PS_FAST : PS_FP;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: bus-level scoreboard for data bits and slave model
  always @(negedge clk) begin
    if (in_byte && !prev_in) begin
      hi = 0; lo = 0; bidx = 0; seen_fall = 1'b0; hi_changed = 1'b0;
    end
    if (in_byte) begin
      if (!scl_pull) begin
        if (prev_scl && seen_fall)
          chk(lo + 1 == cyc(LOWC, cur_p()), "R6 scl low length", lo + 1, cyc(LOWC, cur_p()));
        if (!prev_scl && hi > 0 && sda_pull != prev_sdp) hi_changed = 1'b1;
        hi++;
        last_sda = sda_ln;
      end else if (!prev_scl) begin
        if (hi > 0) begin
          int item, got;
          got = int'(last_sda) * 100000 + hi;
          if (exp_q.size() == 0) chk(1'b0, "R10 unexpected scl pulse", got, 0);
          else begin
            item = exp_q.pop_front();
            chk(got == item, "R6 R2 bit level and high length", got, item);
          end
          chk(!hi_changed, "R7 sda steady while scl high", int'(hi_changed), 0);
          bidx++; hi = 0; lo = 0; seen_fall = 1'b1; hi_changed = 1'b0;
          ext_sda = (bidx < 9) ? slave_bits[bidx] : 1'b0;
        end
      end else if (seen_fall) begin
        lo++;
        if (sda_pull != prev_sdp)
          chk(lo == cyc(DHC, cur_p()), "R6 data hold after scl fall", lo, cyc(DHC, cur_p()));
      end
    end
    prev_scl = scl_pull; prev_sdp = sda_pull; prev_in = in_byte;
  end

  task automatic send_cmd(input logic [1:0] op, input logic [7:0] d, input bit m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d; cmd_mack = m;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_start(input bit rep);
    int su = 0, hd = 0, guard = 0, p;
    bit seen = 0;
    p = cur_p();
    send_cmd(2'd0, 8'h00, 1'b0);
    while (guard < 5000) begin
      if (!scl_pull) begin
        seen = 1;
        if (sda_pull) hd++; else su++;
      end else if (seen) break;
      guard++;
      @(negedge clk);
    end
    if (rep) begin
      chk(hd == cyc(SHC, p), "R5 repeated start hold", hd, cyc(SHC, p));
      chk(su == cyc(SHC, p), "R5 repeated start setup", su, cyc(SHC, p));
    end else begin
      chk(hd == cyc(SHC, p), "R4 start hold", hd, cyc(SHC, p));
    end
    chk(scl_pull && sda_pull, "R4 bus held low after start", int'(scl_pull & sda_pull), 1);
    chk(busy, "R11 busy while holding", int'(busy), 1);
  endtask

  task automatic do_byte(input bit rd, input logic [7:0] data, input bit ack, input bit poke);
    int p, quiet = 0;
    p = cur_p();
    for (int k = 0; k < 8; k++) begin
      slave_bits[k] = rd ? ~data[7-k] : 1'b0;
      exp_q.push_back(int'(data[7-k]) * 100000 + cyc(HIGHC, p));
    end
    slave_bits[8] = rd ? 1'b0 : ack;
    exp_q.push_back((ack ? 0 : 1) * 100000 + cyc(HIGHC, p));
    ext_sda = slave_bits[0];
    in_byte = 1'b1;
    send_cmd(rd ? 2'd2 : 2'd1, rd ? 8'h00 : data, ack);
    if (poke) begin
      repeat (40) @(negedge clk);
      send_cmd(2'd1, 8'h00, 1'b0);  // R10: must not disturb the running byte
    end
    while (exp_q.size() != 0) @(negedge clk);
    in_byte = 1'b0;
    chk(nack == !ack, "R8 ninth bit level", int'(nack), int'(!ack));
    if (rd) chk(rx_data == data, "R8 read data", int'(rx_data), int'(data));
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!scl_pull) quiet++;
    end
    chk(quiet == 0, "R10 no extra activity after byte", quiet, 0);
  endtask

  task automatic do_stop();
    int su = 0, bf = 0, guard = 0, p;
    p = cur_p();
    send_cmd(2'd3, 8'h00, 1'b0);
    while (busy && guard < 5000) begin
      if (!scl_pull) begin
        if (sda_pull) su++; else bf++;
      end
      guard++;
      @(negedge clk);
    end
    chk(su == cyc(SHC, p), "R9 stop setup", su, cyc(SHC, p));
    chk(bf == cyc(BUFC, p), "R9 bus release time", bf, cyc(BUFC, p));
    chk(bus_free, "R9 stop marks bus free", int'(bus_free), 1);
    chk(!scl_pull && !sda_pull, "R11 lines released when idle", int'(scl_pull | sda_pull), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks == 150000) begin
      fails++;
      $display("FAIL R0 watchdog actual=%0d expected=%0d", ticks, 0);
      finish_run();
    end
  end

  initial begin
    int lim;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!scl_pull && !sda_pull, "R1 pulls in reset", int'(scl_pull | sda_pull), 0);
    chk(!busy && !bus_free && !nack && rx_data == 8'h00, "R1 status in reset",
        int'({busy, bus_free, nack}), 0);
    rst_n = 1'b1;
    lim = cyc(IDLEC, cur_p());
    repeat (lim - 2) @(negedge clk);
    chk(!bus_free, "R3 bus not free before idle timeout", int'(bus_free), 0);
    repeat (4) @(negedge clk);
    chk(bus_free, "R3 bus free after idle timeout", int'(bus_free), 1);

    send_cmd(2'd1, 8'h55, 1'b0);
    chk(!busy, "R10 write in idle ignored", int'(busy), 0);

    // Standard class
    do_start(1'b0);
    do_byte(1'b0, 8'hA5, 1'b1, 1'b1);
    do_byte(1'b1, 8'h3C, 1'b1, 1'b0);
    do_start(1'b1);
    do_byte(1'b0, 8'h5A, 1'b0, 1'b0);
    do_stop();

    // R3 recovery: another device disturbs SCL with no STOP
    @(negedge clk); ext_scl = 1'b1;
    repeat (5) @(negedge clk);
    chk(!bus_free, "R3 bus_free cleared by low line", int'(bus_free), 0);
    ext_scl = 1'b0;
    send_cmd(2'd0, 8'h00, 1'b0);
    chk(!busy, "R3 start ignored while bus not free", int'(busy), 0);
    repeat (lim - 4) @(negedge clk);
    chk(!bus_free, "R3 recovery not early", int'(bus_free), 0);
    repeat (4) @(negedge clk);
    chk(bus_free, "R3 recovery by idle timeout", int'(bus_free), 1);

    // Fast-plus class (R2 different prescale)
    mode = 2'd2;
    do_start(1'b0);
    do_byte(1'b0, 8'hC3, 1'b1, 1'b0);
    do_byte(1'b1, 8'h81, 1'b0, 1'b0);
    do_stop();

    // Fast class, prescale of one cycle
    mode = 2'd1;
    do_start(1'b0);
    do_byte(1'b0, 8'h7E, 1'b1, 1'b0);
    do_stop();

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule